// File: doc/BRIEF.md
# Fixed-Priority Non-Preemptive Three-Way Arbiter

This block shares a single resource, for example a bus driven through tri-state buffers, among three requesting devices. Each device raises its own request bit and waits for its own grant bit. The arbiter never asserts more than one grant at a time. When the resource is free, device 1 wins over devices 2 and 3, and device 2 wins over device 3.

A grant does not get taken away. The current holder keeps the resource for as long as its request stays high, even when a device with higher priority is waiting. When the holder lowers its request, the arbiter spends exactly one cycle with no grant. Priority selection then runs again on the requests present at that moment.

The grants are register outputs, decoded from the machine state only, so they change only on a rising clock edge. The reset is active low and asynchronous. It forces the idle state, in which no grant is asserted.

Top module: `prio_arbiter`

## Requirements
- R1: While rst_ni is 0, gnt_o is 3'b000. This holds immediately on reset assertion, without waiting for a clock edge.
- R2: At most one bit of gnt_o is 1 in every cycle.
- R3: With no grant active and req_i[0]=1 at a rising edge, gnt_o becomes 3'b001 (device 1) after that edge, whatever req_i[2:1] is.
- R4: With no grant active, req_i[0]=0 and req_i[1]=1 at a rising edge, gnt_o becomes 3'b010 (device 2) after that edge.
- R5: With no grant active and req_i=3'b100 at a rising edge, gnt_o becomes 3'b100 (device 3) after that edge.
- R6: With no grant active and req_i=3'b000 at a rising edge, gnt_o stays 3'b000.
- R7: While gnt_o[k]=1 and req_i[k]=1 at a rising edge, gnt_o keeps the same value after that edge, whatever the other request bits are. This holds for any number of cycles.
- R8: While gnt_o[k]=1 and req_i[k]=0 at a rising edge, gnt_o becomes 3'b000 after that edge. A new grant can appear no earlier than the following edge.
- R9: A grant bit gnt_o[k] rises only after an edge at which req_i[k] was 1, and it changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request bits; bit 0 is device 1 (highest priority), bit 2 is device 3 |
| gnt_o | output | 3 | Grant bits, registered and one-hot or zero; bit k answers req_i[k] |

## Verification
The hardest case to reach from the ports is a holder that keeps its grant while a higher-priority device is requesting, followed by the idle gap when the holder lets go. Each grant state is first reached by a one-cycle request from a single device. The stimulus then applies every one of the eight request patterns from each of the four states. A long hold with all three requests high checks that there is no preemption. A handover sequence checks that the single empty cycle appears before priority picks the next device.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int unsigned ARB_NREQ = 3;
  localparam int unsigned ARB_SW   = $clog2(ARB_NREQ + 1);

  typedef enum logic [ARB_SW-1:0] {
    ST_IDLE = 2'd0,
    ST_OWN1 = 2'd1,
    ST_OWN2 = 2'd2,
    ST_OWN3 = 2'd3
  } arb_state_e;

  // lowest index wins: returns one-hot of the winning request, or zero
  function automatic logic [ARB_NREQ-1:0] pick_first(input logic [ARB_NREQ-1:0] req);
    logic [ARB_NREQ-1:0] res;
    res = '0;
    for (int i = ARB_NREQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        res    = '0;
        res[i] = 1'b1;
      end
    end
    return res;
  endfunction

  // grant vector owned by a state
  function automatic logic [ARB_NREQ-1:0] gnt_of(input arb_state_e s);
    logic [ARB_NREQ-1:0] g;
    case (s)
      ST_OWN1: g = 3'b001;
      ST_OWN2: g = 3'b010;
      ST_OWN3: g = 3'b100;
      default: g = 3'b000;
    endcase
    return g;
  endfunction

  // state that owns a one-hot grant vector
  function automatic arb_state_e state_for(input logic [ARB_NREQ-1:0] oh);
    arb_state_e s;
    case (oh)
      3'b001:  s = ST_OWN1;
      3'b010:  s = ST_OWN2;
      3'b100:  s = ST_OWN3;
      default: s = ST_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
(
  input  arb_state_e             cur_i,
  input  logic [ARB_NREQ-1:0]    req_i,
  output arb_state_e             nxt_o,
  output logic                   claim_o,
  output logic                   release_o
);

  logic [ARB_NREQ-1:0] winner;
  logic [ARB_NREQ-1:0] owned;
  logic                is_idle;

  assign winner    = pick_first(req_i);
  assign owned     = gnt_of(cur_i);
  assign is_idle   = (cur_i == ST_IDLE);
  assign claim_o   = is_idle && (req_i != '0);
  assign release_o = !is_idle && ((owned & req_i) == '0);

  always_comb begin
    nxt_o = cur_i;
    if (is_idle) begin
      nxt_o = state_for(winner);
    end else if (release_o) begin
      nxt_o = ST_IDLE;
    end
  end

endmodule

// File: rtl/arb_state_reg.sv
module arb_state_reg
  import arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  arb_state_e nxt_i,
  output arb_state_e cur_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= ST_IDLE;
    else         cur_o <= nxt_i;
  end

endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg
  import arb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  arb_state_e          nxt_i,
  output logic [ARB_NREQ-1:0] gnt_o
);

  // grants come straight from flops loaded with the decode of the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_o <= '0;
    else         gnt_o <= gnt_of(nxt_i);
  end

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import arb_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   req_i,
  output logic [2:0]   gnt_o
);

  arb_state_e cur_state;
  arb_state_e nxt_state;
  logic       claim_evt;
  logic       release_evt;

  arb_select u_sel (
    .cur_i     (cur_state),
    .req_i     (req_i),
    .nxt_o     (nxt_state),
    .claim_o   (claim_evt),
    .release_o (release_evt)
  );

  arb_state_reg u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_state),
    .cur_o  (cur_state)
  );

  arb_grant_reg u_gnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_state),
    .gnt_o  (gnt_o)
  );

endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] req_i,
  input logic [2:0] gnt_o,
  input logic       claim_evt,
  input logic       release_evt
);

  assert_reset_idle_R1: assert property (@(posedge clk_i) !rst_ni |-> gnt_o == 3'b000);

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gnt_o));

  assert_pick_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i[0]) |=> gnt_o == 3'b001);

  assert_pick_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i[1:0] == 2'b10) |=> gnt_o == 3'b010);

  assert_pick_third_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i == 3'b100) |=> gnt_o == 3'b100);

  assert_stay_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == 3'b000 && req_i == 3'b000) |=> gnt_o == 3'b000);

  assert_keep_holder_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != 3'b000) |=> $stable(gnt_o));

  assert_release_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_evt |=> gnt_o == 3'b000);

  assert_claim_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_evt |=> gnt_o != 3'b000);

  for (genvar k = 0; k < 3; k++) begin : g_rise
    assert_rise_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_o[k]) |-> $past(req_i[k]));
  end

endmodule

bind prio_arbiter prio_arbiter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .claim_evt   (claim_evt),
  .release_evt (release_evt)
);

// File: tb/prio_arbiter_tb_top.sv
module prio_arbiter_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] req_i = 3'b000;
  logic [2:0] gnt_o;
  logic [2:0] exp_g = 3'b000;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  prio_arbiter dut_i (.clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .gnt_o(gnt_o));

  function automatic logic [2:0] model_next(input logic [2:0] g, input logic [2:0] r);
    if (g == 3'b000) begin
      if (r[0])      return 3'b001;
      else if (r[1]) return 3'b010;
      else if (r[2]) return 3'b100;
      else           return 3'b000;
    end
    if ((g & r) != 3'b000) return g;
    return 3'b000;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: gnt_o actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [2:0] g, input logic [2:0] r);
    if (g == 3'b000) begin
      if (r[0]) return "R3";
      if (r[1]) return "R4";
      if (r[2]) return "R5";
      return "R6";
    end
    if ((g & r) != 3'b000) return "R7";
    return "R8";
  endfunction

  // drive at negedge, sample 2 ns after the next rising edge
  task automatic step(input logic [2:0] r);
    string t;
    @(negedge clk_i);
    req_i = r;
    t = tag_for(exp_g, r);
    exp_g = model_next(exp_g, r);
    @(posedge clk_i);
    #2;
    check(t, gnt_o, exp_g);
    // R2: never more than one grant; R9 covered by the model only granting requested bits
    check("R2", {2'b00, ($countones(gnt_o) > 1)}, 3'b000);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_i = 3'b000;
    #3;
    check("R1", gnt_o, 3'b000);
    exp_g = 3'b000;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #3;
    check("R1", gnt_o, 3'b000);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // every start state crossed with every request pattern
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 8; p++) begin
        do_reset();
        if (s > 0) step(3'(1 << (s - 1)));
        step(3'(p));
      end
    end

    // R7: device 3 holds for many cycles against higher-priority requests
    do_reset();
    step(3'b100);
    for (int i = 0; i < 40; i++) step(3'b111);
    // R8: release gives one empty cycle, then device 1 wins (R3), then hand to device 2 (R4)
    step(3'b011);
    step(3'b011);
    step(3'b010);
    step(3'b010);
    step(3'b110);
    step(3'b100);
    step(3'b100);
    step(3'b000);
    step(3'b000);

    // R1: asynchronous reset while a grant is held
    step(3'b001);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1", gnt_o, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    req_i = 3'b000;
    exp_g = 3'b000;
    step(3'b000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule